// File: doc/BRIEF.md
# UART FIFO and Interrupt Controller

This block sits between a processor-side register bus and the serial engine of a UART. It keeps one byte queue per direction: software pushes bytes for transmission by writing the transmit data port, and the serialiser drains them over a valid/ready byte stream. The deserialiser delivers received bytes over a second valid/ready stream, and software pops them by reading the receive data port. Status, control and threshold registers let software watch queue occupancy, flush each queue, clear the sticky overflow error and pick the occupancy levels that raise the single interrupt line.

Each queue is a small state machine with two named states. `Q_RUN` is normal operation. `Q_HELD` keeps the queue empty while its flush bit is set. The transition `RUN->HELD` is taken when the flush bit is high, and `HELD->RUN` is taken when it goes low. The interrupt line is driven by a second state machine. Its states are `IRQ_IDLE` and `IRQ_RAISED`. The transition `IDLE->RAISED` is taken on a clock edge where an enabled cause holds, and `RAISED->IDLE` is taken on a clock edge where no enabled cause holds. This gives the line one cycle of latency behind the queue levels.

Register map (byte offsets): 0x00 transmit data (write), 0x04 receive data (read), 0x08 control, 0x0C status, 0x10 thresholds.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, status reads 0x0050_0000 (receive empty bit 20 and transmit empty bit 22 set, all levels zero), `irq` is low and `tx_valid` is low.
- R2: Bytes written to offset 0x00 (bits [7:0]) leave on the transmit stream in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R3: Bytes accepted on the receive stream (`rx_valid` and `rx_ready` high) are returned in arrival order by reads of offset 0x04 in bits [7:0], and each read removes one byte.
- R4: A read of offset 0x04 while the receive queue is empty returns 0 and leaves both levels unchanged.
- R5: Status at 0x0C holds the receive level in [7:0], the transmit level in [15:8], receive empty at bit 20, transmit full at bit 21 and transmit empty at bit 22.
- R6: A write to offset 0x00 while the transmit queue is full drops the byte and sets status bit 18, which stays set.
- R7: While control bit 24 is set, status bit 18 is cleared and cannot be set.
- R8: While control bit 22 is set the transmit queue is held empty and `tx_valid` is low; while control bit 23 is set the receive queue is held empty and `rx_ready` is low. Bytes held in a queue when its flush bit is set are discarded.
- R9: With control bit 27 set, `irq` is high while the receive level is at least the receive threshold in bits [7:0] of offset 0x10.
- R10: With control bit 28 set, `irq` is high while the transmit level is below the transmit threshold in bits [15:8] of offset 0x10.
- R11: `rx_ready` is low while the receive queue holds DEPTH bytes.
- R12: `irq` follows its causes one clock after the levels change and is low whenever both enables were clear in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one access per cycle |
| reg_rd_en | input | 1 | Register read strobe; a read of 0x04 pops a byte |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_valid | output | 1 | Transmit queue has a byte to offer |
| tx_ready | input | 1 | Serialiser takes the offered byte |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Receive queue accepts a byte |
| irq | output | 1 | Combined level interrupt |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume the register bus only uses the five offsets listed above, and that `rx_byte` stays stable while `rx_valid` waits for `rx_ready`. The stimulus tasks keep each access to one strobe for one cycle and change all inputs on the falling edge. The receive driver holds its byte until it sees `rx_ready` high, so every property sees legal bus traffic. Interrupt checks wait several cycles after each level change, to allow for the registered line.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_TXDATA = 5'h00;
    localparam logic [REG_AW-1:0] OFS_RXDATA = 5'h04;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h08;
    localparam logic [REG_AW-1:0] OFS_STAT   = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_THR    = 5'h10;

    // control bit positions
    localparam int C_TXFLUSH = 22;
    localparam int C_RXFLUSH = 23;
    localparam int C_CLRERR  = 24;
    localparam int C_RXIE    = 27;
    localparam int C_TXIE    = 28;

    localparam logic [31:0] CTRL_MASK = (32'd1 << C_TXFLUSH) | (32'd1 << C_RXFLUSH)
                                      | (32'd1 << C_CLRERR)  | (32'd1 << C_RXIE)
                                      | (32'd1 << C_TXIE);

    // status bit positions
    localparam int S_OVF     = 18;
    localparam int S_RXEMPTY = 20;
    localparam int S_TXFULL  = 21;
    localparam int S_TXEMPTY = 22;

    typedef enum logic {Q_RUN, Q_HELD} q_state_e;
    typedef enum logic {IRQ_IDLE, IRQ_RAISED} irq_state_e;

endpackage

// File: rtl/uart_fifo_queue.sv
module uart_fifo_queue
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic          has_data,
    output logic          can_push,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    q_state_e         state_q, state_d;
    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    count;
    logic             push_ok, pop_ok, open;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_RUN:  if (flush)  state_d = Q_HELD;
            Q_HELD: if (!flush) state_d = Q_RUN;
        endcase
    end

    // outputs
    always_comb begin
        open = 1'b0;
        unique case (state_q)
            Q_RUN:  open = !flush;
            Q_HELD: open = 1'b0;
        endcase
        full     = open && (count == LW'(DEPTH));
        has_data = open && (count != '0);
        can_push = open && (count != LW'(DEPTH));
        level    = count;
        head     = mem[rd_ptr];
        push_ok  = push && can_push;
        pop_ok   = pop && has_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (state_q)
                Q_RUN: begin
                    if (flush) begin
                        wr_ptr <= '0;
                        rd_ptr <= '0;
                        count  <= '0;
                    end else begin
                        if (push_ok) wr_ptr <= wr_ptr + AW'(1);
                        if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
                        count <= count + LW'(push_ok) - LW'(pop_ok);
                    end
                end
                Q_HELD: begin
                    wr_ptr <= '0;
                    rd_ptr <= '0;
                    count  <= '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_level,
    input  logic [7:0] tx_level,
    input  logic [7:0] rx_thr,
    input  logic [7:0] tx_thr,
    input  logic       rx_en,
    input  logic       tx_en,
    output logic       irq
);
    irq_state_e state_q, state_d;
    logic       cause;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cause   = (rx_en && (rx_level >= rx_thr)) || (tx_en && (tx_level < tx_thr));
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (cause)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!cause) state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            IRQ_IDLE:   irq = 1'b0;
            IRQ_RAISED: irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              irq
);
    localparam int LW = $clog2(DEPTH+1);

    logic [31:0]   ctrl_q;
    logic [15:0]   thr_q;
    logic          ovf_q;
    logic          tx_push, rx_pop, tx_full, rx_full, tx_has, rx_has, rx_can;
    logic [LW-1:0] tx_level, rx_level;
    logic [7:0]    rx_head;
    logic          flush_tx, flush_rx, clr_err, ie_rx, ie_tx, tx_empty, rx_empty;
    logic [31:0]   stat;

    assign flush_tx = ctrl_q[C_TXFLUSH];
    assign flush_rx = ctrl_q[C_RXFLUSH];
    assign clr_err  = ctrl_q[C_CLRERR];
    assign ie_rx    = ctrl_q[C_RXIE];
    assign ie_tx    = ctrl_q[C_TXIE];
    assign tx_push  = reg_wr_en && (reg_addr == OFS_TXDATA);
    assign rx_pop   = reg_rd_en && (reg_addr == OFS_RXDATA);
    assign tx_empty = !tx_has;
    assign rx_empty = !rx_has;

    uart_fifo_queue #(.DEPTH(DEPTH), .DW(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .push(tx_push), .push_data(reg_wdata[7:0]), .pop(tx_ready),
        .head(tx_byte), .level(tx_level), .has_data(tx_has),
        .can_push(), .full(tx_full)
    );

    uart_fifo_queue #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .push(rx_valid), .push_data(rx_byte), .pop(rx_pop),
        .head(rx_head), .level(rx_level), .has_data(rx_has),
        .can_push(rx_can), .full(rx_full)
    );

    assign tx_valid = tx_has;
    assign rx_ready = rx_can;

    uart_fifo_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .rx_level(8'(rx_level)), .tx_level(8'(tx_level)),
        .rx_thr(thr_q[7:0]), .tx_thr(thr_q[15:8]),
        .rx_en(ie_rx), .tx_en(ie_tx), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thr_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (reg_wr_en && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
            if (reg_wr_en && reg_addr == OFS_THR)  thr_q  <= reg_wdata[15:0];
            if (clr_err)                   ovf_q <= 1'b0;
            else if (tx_push && tx_full)   ovf_q <= 1'b1;
        end
    end

    always_comb begin
        stat            = '0;
        stat[7:0]       = 8'(rx_level);
        stat[15:8]      = 8'(tx_level);
        stat[S_OVF]     = ovf_q;
        stat[S_RXEMPTY] = rx_empty;
        stat[S_TXFULL]  = tx_full;
        stat[S_TXEMPTY] = tx_empty;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_RXDATA: reg_rdata = rx_has ? {24'd0, rx_head} : 32'd0;
            OFS_CTRL:   reg_rdata = ctrl_q;
            OFS_STAT:   reg_rdata = stat;
            OFS_THR:    reg_rdata = {16'd0, thr_q};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk
    import uart_fifo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              tx_valid,
    input logic              rx_ready,
    input logic              irq,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              ovf,
    input logic              ie_rx,
    input logic              ie_tx,
    input logic              flush_tx,
    input logic              flush_rx,
    input logic              clr_err
);
    // R5
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == OFS_RXDATA && rx_empty) |-> (reg_rdata == 32'd0));

    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(reg_wr_en && reg_addr == OFS_TXDATA && tx_full));

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> !ovf);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx |=> !tx_valid);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rx |=> !rx_ready);

    // R11
    rx_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_ready);

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_rx && !ie_tx) |=> !irq);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .rx_ready(rx_ready), .irq(irq), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .ovf(ovf_q), .ie_rx(ie_rx),
    .ie_tx(ie_tx), .flush_tx(flush_tx), .flush_rx(flush_rx), .clr_err(clr_err)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] tx_exp[$];
    logic [7:0] rx_exp[$];

    always #10 clk = ~clk;

    uart_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] b, input bit expect_kept);
        if (expect_kept) tx_exp.push_back(b);
        reg_write(5'h00, {24'd0, b});
    endtask

    task automatic rx_send(input logic [7:0] b, input bit track);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        #1;
        for (int k = 0; k < 50 && !rx_ready; k++) begin
            @(negedge clk);
            #1;
        end
        if (track) rx_exp.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_read_check(input string req);
        logic [31:0] d;
        logic [7:0]  e;
        reg_read(5'h04, d);
        e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 8'h00;
        check(req, d, {24'd0, e});
    endtask

    task automatic stat_check(input string req, input logic [31:0] exp);
        logic [31:0] d;
        reg_read(5'h0C, d);
        check(req, d, exp);
    endtask

    // transmit scoreboard monitor (R2)
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_exp.size() == 0) check("R2 unexpected tx byte", {24'd0, tx_byte}, 32'hxxxx_xxxx);
            else check("R2 tx order", {24'd0, tx_byte}, {24'd0, tx_exp.pop_front()});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        stat_check("R1 status", 32'h0050_0000);

        // R2 / R5: three bytes queued, then drained in order
        tx_write(8'hA5, 1); tx_write(8'h3C, 1); tx_write(8'h0F, 1);
        stat_check("R5 tx level 3", 32'h0010_0300);
        tx_ready = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 all sent", tx_exp.size(), 0);
        stat_check("R5 drained", 32'h0050_0000);

        // R6 / R7: fill, overflow, clear
        tx_ready = 1'b0;
        for (int i = 0; i < 64; i++) tx_write(8'(i * 7 + 1), 1);
        stat_check("R5 tx full", 32'h0030_4000);
        tx_write(8'hEE, 0);
        stat_check("R6 overflow set", 32'h0034_4000);
        stat_check("R6 overflow sticky", 32'h0034_4000);
        reg_write(5'h08, 32'h0100_0000);
        stat_check("R7 cleared while set", 32'h0030_4000);
        reg_read(5'h08, d);
        check("R7 control readback", d, 32'h0100_0000);
        reg_write(5'h08, 32'h0);
        tx_ready = 1'b1;
        repeat (80) @(negedge clk);
        check("R6 dropped byte not sent", tx_exp.size(), 0);
        stat_check("R7 empty after drain", 32'h0050_0000);

        // R3 / R4 / R5 receive path
        rx_send(8'h11, 1); rx_send(8'h22, 1); rx_send(8'h33, 1);
        stat_check("R5 rx level 3", 32'h0040_0003);
        rx_read_check("R3 first");
        rx_read_check("R3 second");
        rx_read_check("R3 third");
        reg_read(5'h04, d);
        check("R4 empty read zero", d, 32'd0);
        stat_check("R4 levels unchanged", 32'h0050_0000);

        // R9 receive interrupt
        reg_write(5'h10, 32'h0000_0002);
        reg_write(5'h08, 32'h0800_0000);
        rx_send(8'h44, 1);
        repeat (3) @(negedge clk);
        check("R9 below threshold", {31'd0, irq}, 32'd0);
        rx_send(8'h55, 1);
        repeat (3) @(negedge clk);
        check("R9 at threshold", {31'd0, irq}, 32'd1);
        rx_read_check("R9 read");
        repeat (3) @(negedge clk);
        check("R9 dropped below", {31'd0, irq}, 32'd0);
        rx_read_check("R3 remaining");

        // R10 transmit interrupt
        reg_write(5'h10, 32'h0000_0200);
        reg_write(5'h08, 32'h1000_0000);
        repeat (3) @(negedge clk);
        check("R10 empty below thr", {31'd0, irq}, 32'd1);
        tx_ready = 1'b0;
        tx_write(8'h61, 1); tx_write(8'h62, 1);
        repeat (3) @(negedge clk);
        check("R10 level at thr", {31'd0, irq}, 32'd0);
        tx_ready = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 drained", {31'd0, irq}, 32'd1);

        // R12: masking
        reg_write(5'h08, 32'h0);
        repeat (2) @(negedge clk);
        check("R12 masked", {31'd0, irq}, 32'd0);

        // R8 transmit flush
        tx_ready = 1'b0;
        tx_write(8'h71, 0); tx_write(8'h72, 0); tx_write(8'h73, 0);
        reg_write(5'h08, 32'h0040_0000);
        #1 check("R8 tx_valid held", {31'd0, tx_valid}, 32'd0);
        stat_check("R8 tx held empty", 32'h0050_0000);
        reg_write(5'h08, 32'h0);
        tx_ready = 1'b1;
        repeat (5) @(negedge clk);
        stat_check("R8 tx flushed", 32'h0050_0000);

        // R8 receive flush
        rx_send(8'h81, 0); rx_send(8'h82, 0);
        reg_write(5'h08, 32'h0080_0000);
        #1 check("R8 rx_ready held", {31'd0, rx_ready}, 32'd0);
        reg_write(5'h08, 32'h0);
        reg_read(5'h04, d);
        check("R8 rx flushed", d, 32'd0);

        // R11 receive full backpressure
        for (int i = 0; i < 64; i++) rx_send(8'(i + 100), 1);
        @(negedge clk);
        #1 check("R11 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
        stat_check("R11 rx level 64", 32'h0040_0040);
        for (int i = 0; i < 64; i++) rx_read_check("R3 full drain");
        stat_check("R3 rx empty", 32'h0050_0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule